// File: doc/BRIEF.md
# Multi-Source Reset Controller

This block gathers the internal reasons a processor subsystem must restart and turns them into one reset sequence. It watches four request sources:

- an illegal instruction reported by the decoder, where a stop instruction counts as illegal while stop is not permitted;
- an instruction fetch from an address that no resource decodes;
- a low-supply warning;
- a request to enter debug mode.

While a sequence runs, the block pulls the external reset pin low and holds the CPU in reset.

A sequence has two timed phases, both paced by one shared counter. In the hold phase the pin is driven low. A sequence started by a low-supply warning holds for 4096 + 32 cycles, and any other sequence holds for 32 cycles. In the release phase that follows, the pin is let go but the CPU stays in reset for 32 more cycles. Only then may it begin fetching its reset vector.

A sticky status register records which sources caused the reset. Software reads it after restart, and the read clears it. Power-on reset is an asynchronous input that puts the block into its idle state.

The controller is one state machine with three states:

- `SEQ_IDLE`: normal running.
- `SEQ_HOLD`: pin low, CPU in reset.
- `SEQ_RELEASE`: pin released, CPU still in reset.

It has four named transitions:

- T_START: `SEQ_IDLE` to `SEQ_HOLD` on any request.
- T_RESTART: a request in `SEQ_HOLD` or `SEQ_RELEASE` goes to `SEQ_HOLD` with the count at zero.
- T_HOLD_DONE: `SEQ_HOLD` to `SEQ_RELEASE` when the hold count ends.
- T_RELEASE_DONE: `SEQ_RELEASE` to `SEQ_IDLE` when the release count ends.

Top module: `rst_ctrl`

## Requirements
- R1: While `por_n` is low and right after it rises, `pin_drive_low` is 0, `cpu_rst` is 0 and `stat_flags` is 0000.
- R2: A cycle with `instr_illegal` high sets `stat_flags[0]` (illegal opcode) and starts a reset sequence.
- R3: A cycle with `instr_stop` high and `stop_allow` low is an illegal opcode: it sets `stat_flags[0]` and starts a sequence. With `stop_allow` high, a stop instruction has no effect on the pin, the CPU reset or the flags.
- R4: A cycle with `fetch_strobe` high and `addr_mapped` low sets `stat_flags[1]` and starts a sequence. An unmapped access with `fetch_strobe` low has no effect.
- R5: A cycle with `low_volt` high sets `stat_flags[2]`. From the next clock edge, `pin_drive_low` is high for exactly 4128 cycles.
- R6: After the pin hold ends, `cpu_rst` stays high with `pin_drive_low` low for exactly 32 cycles, then falls.
- R7: A cycle with `dbg_entry` high sets `stat_flags[3]` and starts a sequence. A sequence with no low-supply request holds the pin for exactly 32 cycles.
- R8: Every sequence drives `pin_drive_low` high, and `cpu_rst` is high whenever `pin_drive_low` is high.
- R9: Flags stay set after the sequence ends until a cycle with `stat_rd` high, which clears them all. A source requesting in that same cycle leaves its flag set.
- R10: Sources requesting in the same cycle all set their flags, and one sequence runs. Its hold is the long one if the low-supply source is among them.
- R11: A request during a running sequence restarts the hold phase with the count at zero. The hold is long if a low-supply request has arrived at any point since the sequence began.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| fetch_strobe | input | 1 | Current bus access is an instruction fetch |
| addr_mapped | input | 1 | Current access address is decoded by some resource |
| instr_illegal | input | 1 | Decoder found an undefined instruction (one-cycle pulse) |
| instr_stop | input | 1 | Decoder found a stop instruction (one-cycle pulse) |
| stop_allow | input | 1 | Configuration: stop instruction permitted |
| low_volt | input | 1 | Low-supply warning from the voltage monitor |
| dbg_entry | input | 1 | Debug-mode entry requests a reset |
| stat_rd | input | 1 | Status register read strobe; clears the flags |
| pin_drive_low | output | 1 | Pull the external reset pin low |
| cpu_rst | output | 1 | Hold the CPU in reset |
| stat_flags | output | 4 | [0] illegal opcode, [1] illegal address, [2] low supply, [3] debug entry |

## Verification
Directed cases cover each source on its own and the two look-alikes that must not trigger a reset: a data access to an unmapped address, and a stop instruction while stop is allowed. These show that the qualifiers, not the raw events, start a sequence. Measured pin-low and release lengths for a short source, a low-supply source, a simultaneous mix, a short restart, and a short request landing inside a long hold separate the short and long hold paths and show that a restart counts from zero. A long seeded random run mixes all inputs and read strobes at varied rates. Each cycle it is compared with a cycle model in the bench, which exposes ordering faults such as a clear beating a set, or a restart arriving in the release phase.

// File: rtl/rst_ctrl_pkg.sv
package rst_ctrl_pkg;

    // Sequencer states
    typedef enum logic [1:0] {
        SEQ_IDLE    = 2'd0,
        SEQ_HOLD    = 2'd1,
        SEQ_RELEASE = 2'd2
    } seq_state_e;

    // Reset source indices; these are also the status bit positions
    localparam int SRC_N        = 4;
    localparam int SRC_ILL_OP   = 0;
    localparam int SRC_ILL_ADDR = 1;
    localparam int SRC_LOWV     = 2;
    localparam int SRC_DBG      = 3;

    typedef logic [SRC_N-1:0] src_vec_t;

endpackage

// File: rtl/rst_ctrl_src.sv
module rst_ctrl_src
    import rst_ctrl_pkg::*;
(
    input  logic     fetch_strobe,
    input  logic     addr_mapped,
    input  logic     instr_illegal,
    input  logic     instr_stop,
    input  logic     stop_allow,
    input  logic     low_volt,
    input  logic     dbg_entry,
    output src_vec_t req,
    output logic     any_req
);

    always_comb begin
        req               = '0;
        // A stop instruction is illegal while stop is not permitted
        req[SRC_ILL_OP]   = instr_illegal | (instr_stop & ~stop_allow);
        // Unmapped address only counts on an instruction fetch
        req[SRC_ILL_ADDR] = fetch_strobe & ~addr_mapped;
        req[SRC_LOWV]     = low_volt;
        req[SRC_DBG]      = dbg_entry;
        any_req           = |req;
    end

endmodule

// File: rtl/rst_ctrl_status.sv
module rst_ctrl_status
    import rst_ctrl_pkg::*;
(
    input  logic     clk,
    input  logic     por_n,
    input  src_vec_t req,
    input  logic     rd_clr,
    output src_vec_t flags
);

    // One sticky flag per source; a set in the read cycle beats the clear
    for (genvar i = 0; i < SRC_N; i++) begin : g_flag
        always_ff @(posedge clk or negedge por_n) begin
            if (!por_n) begin
                flags[i] <= 1'b0;
            end else if (req[i]) begin
                flags[i] <= 1'b1;
            end else if (rd_clr) begin
                flags[i] <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/rst_ctrl_seq.sv
module rst_ctrl_seq
    import rst_ctrl_pkg::*;
#(
    parameter int BASE_HOLD   = 4096,
    parameter int PAD_HOLD    = 32,
    parameter int SHORT_HOLD  = 32,
    parameter int RELEASE_CYC = 32
) (
    input  logic clk,
    input  logic por_n,
    input  logic any_req,
    input  logic long_req,
    output logic pin_drive_low,
    output logic cpu_rst
);

    localparam int LONG_HOLD = BASE_HOLD + PAD_HOLD;
    localparam int MAX_A     = (LONG_HOLD > SHORT_HOLD) ? LONG_HOLD : SHORT_HOLD;
    localparam int MAX_CNT   = (MAX_A > RELEASE_CYC) ? MAX_A : RELEASE_CYC;
    localparam int CW        = $clog2(MAX_CNT + 1);

    localparam logic [CW-1:0] LONG_LAST  = CW'(LONG_HOLD - 1);
    localparam logic [CW-1:0] SHORT_LAST = CW'(SHORT_HOLD - 1);
    localparam logic [CW-1:0] REL_LAST   = CW'(RELEASE_CYC - 1);

    seq_state_e    state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          long_q, long_d;
    logic [CW-1:0] hold_last;

    assign hold_last = long_q ? LONG_LAST : SHORT_LAST;

    // State register process
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            state_q <= SEQ_IDLE;
            cnt_q   <= '0;
            long_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            long_q  <= long_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        long_d  = long_q;
        unique case (state_q)
            SEQ_IDLE: begin
                if (any_req) begin                 // T_START
                    state_d = SEQ_HOLD;
                    cnt_d   = '0;
                    long_d  = long_req;
                end
            end
            SEQ_HOLD: begin
                if (any_req) begin                 // T_RESTART
                    cnt_d  = '0;
                    long_d = long_q | long_req;
                end else if (cnt_q == hold_last) begin  // T_HOLD_DONE
                    state_d = SEQ_RELEASE;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + CW'(1);
                end
            end
            SEQ_RELEASE: begin
                if (any_req) begin                 // T_RESTART
                    state_d = SEQ_HOLD;
                    cnt_d   = '0;
                    long_d  = long_q | long_req;
                end else if (cnt_q == REL_LAST) begin   // T_RELEASE_DONE
                    state_d = SEQ_IDLE;
                    cnt_d   = '0;
                    long_d  = 1'b0;
                end else begin
                    cnt_d = cnt_q + CW'(1);
                end
            end
            default: begin
                state_d = SEQ_IDLE;
                cnt_d   = '0;
                long_d  = 1'b0;
            end
        endcase
    end

    // Output process
    always_comb begin
        pin_drive_low = 1'b0;
        cpu_rst       = 1'b0;
        unique case (state_q)
            SEQ_IDLE: begin
                pin_drive_low = 1'b0;
                cpu_rst       = 1'b0;
            end
            SEQ_HOLD: begin
                pin_drive_low = 1'b1;
                cpu_rst       = 1'b1;
            end
            SEQ_RELEASE: begin
                pin_drive_low = 1'b0;
                cpu_rst       = 1'b1;
            end
            default: begin
                pin_drive_low = 1'b0;
                cpu_rst       = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/rst_ctrl.sv
module rst_ctrl
    import rst_ctrl_pkg::*;
#(
    parameter int BASE_HOLD   = 4096,
    parameter int PAD_HOLD    = 32,
    parameter int SHORT_HOLD  = 32,
    parameter int RELEASE_CYC = 32
) (
    input  logic       clk,
    input  logic       por_n,
    input  logic       fetch_strobe,
    input  logic       addr_mapped,
    input  logic       instr_illegal,
    input  logic       instr_stop,
    input  logic       stop_allow,
    input  logic       low_volt,
    input  logic       dbg_entry,
    input  logic       stat_rd,
    output logic       pin_drive_low,
    output logic       cpu_rst,
    output logic [3:0] stat_flags
);

    src_vec_t req;
    logic     any_req;
    src_vec_t flags;

    rst_ctrl_src u_src (
        .fetch_strobe (fetch_strobe),
        .addr_mapped  (addr_mapped),
        .instr_illegal(instr_illegal),
        .instr_stop   (instr_stop),
        .stop_allow   (stop_allow),
        .low_volt     (low_volt),
        .dbg_entry    (dbg_entry),
        .req          (req),
        .any_req      (any_req)
    );

    rst_ctrl_status u_status (
        .clk   (clk),
        .por_n (por_n),
        .req   (req),
        .rd_clr(stat_rd),
        .flags (flags)
    );

    rst_ctrl_seq #(
        .BASE_HOLD  (BASE_HOLD),
        .PAD_HOLD   (PAD_HOLD),
        .SHORT_HOLD (SHORT_HOLD),
        .RELEASE_CYC(RELEASE_CYC)
    ) u_seq (
        .clk          (clk),
        .por_n        (por_n),
        .any_req      (any_req),
        .long_req     (req[SRC_LOWV]),
        .pin_drive_low(pin_drive_low),
        .cpu_rst      (cpu_rst)
    );

    assign stat_flags = flags;

endmodule

// File: rtl/rst_ctrl_chk.sv
module rst_ctrl_chk #(
    parameter int BASE_HOLD   = 4096,
    parameter int PAD_HOLD    = 32,
    parameter int SHORT_HOLD  = 32,
    parameter int RELEASE_CYC = 32
) (
    input logic       clk,
    input logic       por_n,
    input logic       fetch_strobe,
    input logic       addr_mapped,
    input logic       instr_illegal,
    input logic       instr_stop,
    input logic       stop_allow,
    input logic       low_volt,
    input logic       dbg_entry,
    input logic       stat_rd,
    input logic       pin_drive_low,
    input logic       cpu_rst,
    input logic [3:0] stat_flags
);

    localparam int LONG_HOLD = BASE_HOLD + PAD_HOLD;

    logic bad_op, bad_addr, any_req;
    assign bad_op   = instr_illegal | (instr_stop & ~stop_allow);
    assign bad_addr = fetch_strobe & ~addr_mapped;
    assign any_req  = bad_op | bad_addr | low_volt | dbg_entry;

    int pin_cnt;
    int rel_cnt;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            pin_cnt <= 0;
            rel_cnt <= 0;
        end else begin
            if (any_req)            pin_cnt <= 0;
            else if (pin_drive_low) pin_cnt <= pin_cnt + 1;
            else                    pin_cnt <= 0;
            if (any_req)                        rel_cnt <= 0;
            else if (cpu_rst && !pin_drive_low) rel_cnt <= rel_cnt + 1;
            else                                rel_cnt <= 0;
        end
    end

    p_idle_after_por_r1: assert property (@(posedge clk) disable iff (!por_n)
        ($rose(por_n)) |-> (!pin_drive_low && !cpu_rst));

    p_ill_op_flag_r2: assert property (@(posedge clk) disable iff (!por_n)
        instr_illegal |=> stat_flags[0]);

    p_stop_ok_r3: assert property (@(posedge clk) disable iff (!por_n)
        (instr_stop && stop_allow && !instr_illegal && !bad_addr && !low_volt
         && !dbg_entry && !cpu_rst) |=> !cpu_rst);

    p_data_fetch_ignored_r4: assert property (@(posedge clk) disable iff (!por_n)
        (!fetch_strobe && !bad_op && !low_volt && !dbg_entry && !cpu_rst) |=> !cpu_rst);

    p_lowv_flag_r5: assert property (@(posedge clk) disable iff (!por_n)
        low_volt |=> stat_flags[2]);

    p_hold_len_r5: assert property (@(posedge clk) disable iff (!por_n)
        $fell(pin_drive_low) |-> (pin_cnt == SHORT_HOLD || pin_cnt == LONG_HOLD));

    p_release_len_r6: assert property (@(posedge clk) disable iff (!por_n)
        $fell(cpu_rst) |-> (rel_cnt == RELEASE_CYC));

    p_dbg_flag_r7: assert property (@(posedge clk) disable iff (!por_n)
        dbg_entry |=> stat_flags[3]);

    p_pin_implies_cpu_r8: assert property (@(posedge clk) disable iff (!por_n)
        pin_drive_low |-> cpu_rst);

    p_read_clears_r9: assert property (@(posedge clk) disable iff (!por_n)
        (stat_rd && !any_req) |=> (stat_flags == 4'b0000));

    p_multi_flags_r10: assert property (@(posedge clk) disable iff (!por_n)
        (instr_illegal && dbg_entry) |=> (stat_flags[0] && stat_flags[3]));

    p_req_restarts_r11: assert property (@(posedge clk) disable iff (!por_n)
        any_req |=> (pin_drive_low && cpu_rst));

endmodule

bind rst_ctrl rst_ctrl_chk #(
    .BASE_HOLD  (BASE_HOLD),
    .PAD_HOLD   (PAD_HOLD),
    .SHORT_HOLD (SHORT_HOLD),
    .RELEASE_CYC(RELEASE_CYC)
) u_chk (
    .clk          (clk),
    .por_n        (por_n),
    .fetch_strobe (fetch_strobe),
    .addr_mapped  (addr_mapped),
    .instr_illegal(instr_illegal),
    .instr_stop   (instr_stop),
    .stop_allow   (stop_allow),
    .low_volt     (low_volt),
    .dbg_entry    (dbg_entry),
    .stat_rd      (stat_rd),
    .pin_drive_low(pin_drive_low),
    .cpu_rst      (cpu_rst),
    .stat_flags   (stat_flags)
);

// File: tb/tb_rst_ctrl.sv
module tb_rst_ctrl;

    localparam int CLK_P     = 10;
    localparam int SHORT_LEN = 32;
    localparam int LONG_LEN  = 4096 + 32;
    localparam int REL_LEN   = 32;
    localparam int WD_CYC    = 190000;

    logic       clk = 1'b0;
    logic       por_n = 1'b0;
    logic       fetch_strobe = 1'b0, addr_mapped = 1'b1, instr_illegal = 1'b0;
    logic       instr_stop = 1'b0, stop_allow = 1'b0, low_volt = 1'b0;
    logic       dbg_entry = 1'b0, stat_rd = 1'b0;
    logic       pin_drive_low, cpu_rst;
    logic [3:0] stat_flags;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    rst_ctrl dut (
        .clk(clk), .por_n(por_n), .fetch_strobe(fetch_strobe), .addr_mapped(addr_mapped),
        .instr_illegal(instr_illegal), .instr_stop(instr_stop), .stop_allow(stop_allow),
        .low_volt(low_volt), .dbg_entry(dbg_entry), .stat_rd(stat_rd),
        .pin_drive_low(pin_drive_low), .cpu_rst(cpu_rst), .stat_flags(stat_flags)
    );

    // Reference model built from the requirements
    int       m_state = 0;   // 0 idle, 1 hold, 2 release
    int       m_cnt = 0;
    bit       m_long = 1'b0;
    bit [3:0] m_flags = 4'b0;

    function automatic bit [3:0] f_req(bit f, bit m, bit ill, bit stp, bit alw, bit lv, bit dbg);
        bit [3:0] r;
        r[0] = ill | (stp & ~alw);
        r[1] = f & ~m;
        r[2] = lv;
        r[3] = dbg;
        return r;
    endfunction

    always @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            m_state = 0; m_cnt = 0; m_long = 1'b0; m_flags = 4'b0;
        end else begin
            bit [3:0] r;
            r = f_req(fetch_strobe, addr_mapped, instr_illegal, instr_stop, stop_allow,
                      low_volt, dbg_entry);
            for (int i = 0; i < 4; i++) begin
                if (r[i]) m_flags[i] = 1'b1;
                else if (stat_rd) m_flags[i] = 1'b0;
            end
            if (r != 4'b0) begin
                m_long  = (m_state == 0) ? r[2] : (m_long | r[2]);
                m_state = 1;
                m_cnt   = 0;
            end else if (m_state == 1) begin
                if (m_cnt == (m_long ? LONG_LEN : SHORT_LEN) - 1) begin
                    m_state = 2; m_cnt = 0;
                end else m_cnt++;
            end else if (m_state == 2) begin
                if (m_cnt == REL_LEN - 1) begin
                    m_state = 0; m_cnt = 0; m_long = 1'b0;
                end else m_cnt++;
            end
        end
    end

    task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_errors++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    // Advance one cycle and compare against the model at the falling edge
    task automatic step();
        @(negedge clk);
        chk("R8 pin vs model", 32'(pin_drive_low), 32'(m_state == 1));
        chk("R6 cpu_rst vs model", 32'(cpu_rst), 32'(m_state != 0));
        chk("R9 flags vs model", 32'(stat_flags), 32'(m_flags));
    endtask

    task automatic clear_in();
        fetch_strobe = 1'b0; addr_mapped = 1'b1; instr_illegal = 1'b0;
        instr_stop = 1'b0; low_volt = 1'b0; dbg_entry = 1'b0; stat_rd = 1'b0;
    endtask

    // Count pin-low samples, then release samples, from the current sample on
    task automatic measure(output int hi, output int rel);
        hi = 0; rel = 0;
        while (pin_drive_low) begin hi++; step(); end
        while (cpu_rst && !pin_drive_low) begin rel++; step(); end
    endtask

    task automatic read_status();
        stat_rd = 1'b1; step(); stat_rd = 1'b0;
    endtask

    initial begin
        int hi, rel;
        void'($urandom(32'h00C0FFEE));
        repeat (3) @(negedge clk);
        chk("R1 pin in por", 32'(pin_drive_low), 0);
        chk("R1 cpu in por", 32'(cpu_rst), 0);
        por_n = 1'b1;
        step();
        chk("R1 flags after por", 32'(stat_flags), 0);
        chk("R1 cpu after por", 32'(cpu_rst), 0);

        // R4: unmapped data access is ignored
        addr_mapped = 1'b0; fetch_strobe = 1'b0; step(); clear_in(); step();
        chk("R4 data access no reset", 32'(cpu_rst), 0);
        chk("R4 data access no flag", 32'(stat_flags), 0);

        // R3: permitted stop is ignored
        instr_stop = 1'b1; stop_allow = 1'b1; step(); clear_in(); step();
        chk("R3 allowed stop no reset", 32'(cpu_rst), 0);
        chk("R3 allowed stop no flag", 32'(stat_flags), 0);

        // R2: illegal instruction, short hold and release
        instr_illegal = 1'b1; step(); clear_in();
        measure(hi, rel);
        chk("R2 illegal hold length", 32'(hi), SHORT_LEN);
        chk("R6 release length", 32'(rel), REL_LEN);
        chk("R9 flag sticky after seq", 32'(stat_flags), 4'b0001);
        read_status(); step();
        chk("R9 read clears", 32'(stat_flags), 0);

        // R3: disallowed stop is illegal
        instr_stop = 1'b1; stop_allow = 1'b0; step(); clear_in();
        chk("R3 disallowed stop resets", 32'(cpu_rst), 1);
        measure(hi, rel);
        chk("R3 disallowed stop flag", 32'(stat_flags), 4'b0001);
        read_status();

        // R4: unmapped instruction fetch
        addr_mapped = 1'b0; fetch_strobe = 1'b1; step(); clear_in();
        measure(hi, rel);
        chk("R4 fetch hold", 32'(hi), SHORT_LEN);
        chk("R4 fetch flag", 32'(stat_flags), 4'b0010);
        read_status();

        // R7: debug entry
        dbg_entry = 1'b1; step(); clear_in();
        measure(hi, rel);
        chk("R7 debug hold", 32'(hi), SHORT_LEN);
        chk("R7 debug flag", 32'(stat_flags), 4'b1000);
        read_status();

        // R5/R6: low supply
        low_volt = 1'b1; step(); clear_in();
        measure(hi, rel);
        chk("R5 low supply hold", 32'(hi), LONG_LEN);
        chk("R6 low supply release", 32'(rel), REL_LEN);
        chk("R5 low supply flag", 32'(stat_flags), 4'b0100);
        read_status();

        // R10: simultaneous short sources
        instr_illegal = 1'b1; dbg_entry = 1'b1; addr_mapped = 1'b0; fetch_strobe = 1'b1;
        step(); clear_in();
        measure(hi, rel);
        chk("R10 single short hold", 32'(hi), SHORT_LEN);
        chk("R10 all flags", 32'(stat_flags), 4'b1011);
        read_status();

        // R10: simultaneous with low supply takes long hold
        dbg_entry = 1'b1; low_volt = 1'b1; step(); clear_in();
        measure(hi, rel);
        chk("R10 mix long hold", 32'(hi), LONG_LEN);
        chk("R10 mix flags", 32'(stat_flags), 4'b1100);
        read_status();

        // R11: restart during short hold
        instr_illegal = 1'b1; step(); clear_in();
        repeat (9) step();
        dbg_entry = 1'b1; step(); clear_in();
        measure(hi, rel);
        chk("R11 restarted hold total", 32'(hi + 10), 10 + SHORT_LEN);
        chk("R11 restart release", 32'(rel), REL_LEN);
        read_status();

        // R11: short request inside long hold keeps the long length
        low_volt = 1'b1; step(); clear_in();
        repeat (99) step();
        instr_illegal = 1'b1; step(); clear_in();
        measure(hi, rel);
        chk("R11 long kept after restart", 32'(hi + 100), 100 + LONG_LEN);
        read_status();

        // R11: request during release restarts the hold
        dbg_entry = 1'b1; step(); clear_in();
        measure(hi, rel);
        // now at first idle sample; run a fresh one and hit release
        dbg_entry = 1'b1; step(); clear_in();
        repeat (SHORT_LEN + 4) step();
        chk("R11 in release phase", 32'(pin_drive_low), 0);
        instr_illegal = 1'b1; step(); clear_in();
        chk("R11 release restart pin", 32'(pin_drive_low), 1);
        measure(hi, rel);
        chk("R11 release restart hold", 32'(hi), SHORT_LEN);

        // R9: new set in the read cycle survives
        dbg_entry = 1'b1; step(); clear_in();
        measure(hi, rel);
        stat_rd = 1'b1; instr_illegal = 1'b1; step(); clear_in();
        chk("R9 set beats clear", 32'(stat_flags), 4'b0001);
        measure(hi, rel);
        read_status();

        // Seeded random traffic against the model
        for (int c = 0; c < 30000; c++) begin
            fetch_strobe  = ($urandom % 4) == 0;
            addr_mapped   = ($urandom % 16) != 0;
            instr_illegal = ($urandom % 250) == 0;
            instr_stop    = ($urandom % 120) == 0;
            stop_allow    = ($urandom % 2) == 0;
            low_volt      = ($urandom % 7000) == 0;
            dbg_entry     = ($urandom % 400) == 0;
            stat_rd       = ($urandom % 40) == 0;
            step();
        end
        clear_in();
        step();

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (WD_CYC) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: got %0d expected %0d cycles", WD_CYC, 0);
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

endmodule